// File: doc/BRIEF.md
# Latched Clear-on-Read Tributary Event Counters

This block keeps running tallies of three per-cycle event strobes seen on one virtual-tributary channel: BIP-2 parity errors, REI-V remote error indications and payload pointer decrements. Each tally runs freely in a live counter. A rising edge on a global snapshot control copies all three live tallies into holding registers. In the same cycle the live counters start counting again.

A host reads the holding registers one byte at a time through a registered read port. The two 12-bit tallies each span two bytes. One byte carries the pointer-decrement tally in its upper nibble and the upper bits of the REI-V tally in its lower nibble. Reading a byte returns its contents and then zeroes only the fields inside that byte. Each byte therefore reports what was captured since it was last read.

Top module: `trib_event_counters`

## Requirements
- R1: A synchronous active-high reset zeroes every live counter, every holding field and `rd_data_o`.
- R2: The BIP-2 tally is 12 bits wide. Byte offset 0 returns bits 7:0. Byte offset 1 returns bits 11:8 in bits 3:0, with bits 7:4 read as zero.
- R3: The REI-V tally is 12 bits wide and the pointer-decrement tally is 4 bits wide. Byte offset 2 returns REI-V bits 7:0. Byte offset 3 returns the pointer-decrement tally in bits 7:4 and REI-V bits 11:8 in bits 3:0.
- R4: A live counter that has reached all-ones holds that value when further events arrive. It does not wrap.
- R5: The holding fields load from the live counters only in a cycle where `latch_ctl_i` is 1 after having been 0 in the cycle before. Keeping `latch_ctl_i` at 1 does not load them again.
- R6: In a snapshot cycle each live counter restarts at 0, or at 1 if its strobe is high in that same cycle, so no event is lost.
- R7: A read with `rd_en_i` high returns the addressed byte on `rd_data_o` after the next clock edge. From that edge on, only the fields in that byte read as zero. All other bytes keep their values.
- R8: If a snapshot and a read of the same byte fall in one cycle, the read returns the previous snapshot, and the new snapshot is kept rather than cleared.
- R9: A read of any offset above 3 returns 0x00 and clears nothing.
- R10: While `rd_en_i` is low, `rd_data_o` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bip_err_i | input | 1 | One BIP-2 parity error in this cycle |
| rei_evt_i | input | 1 | One REI-V indication in this cycle |
| ptr_dec_i | input | 1 | One payload pointer decrement in this cycle |
| latch_ctl_i | input | 1 | Snapshot control level; its 0-to-1 edge captures the tallies |
| rd_en_i | input | 1 | Host read strobe |
| rd_addr_i | input | ADDR_W | Byte offset of the read |
| rd_data_o | output | 8 | Registered read data |

## Verification
The bench goes after saturation by sending 4100 BIP-2 events and 20 pointer decrements. A wrapping counter would report small values instead of 0xFFF and 0xF. It holds the snapshot control high while more events arrive. A level-sensitive design would then fold those events into the first read. It also raises a strobe in the snapshot cycle itself, and a design that zeroes the live counter outright would lose that event. Reads of each half of a split tally, and of the shared byte, show whether the design wrongly clears a neighbouring byte. A snapshot that coincides with a read shows whether the fresh capture gets wiped.

// File: rtl/trib_cnt_pkg.sv
package trib_cnt_pkg;
  localparam int BYTE_W     = 8;
  localparam int N_WIDE     = 2;
  localparam int IDX_BIP    = 0;
  localparam int IDX_REI    = 1;
  // host byte offsets
  localparam int OFS_BIP_LO = 0;
  localparam int OFS_BIP_HI = 1;
  localparam int OFS_REI_LO = 2;
  localparam int OFS_SHARED = 3;
endpackage

// File: rtl/trib_live_cnt.sv
module trib_live_cnt #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         evt_i,
  input  logic         restart_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
    end else if (restart_i) begin
      cnt_o <= {{(W-1){1'b0}}, evt_i};
    end else if (evt_i && (cnt_o != CNT_MAX)) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/trib_hold_slice.sv
module trib_hold_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  // a fresh snapshot wins over a read-clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= '0;
    end else if (load_i) begin
      q_o <= load_val_i;
    end else if (clr_i) begin
      q_o <= '0;
    end
  end
endmodule

// File: rtl/trib_event_counters.sv
module trib_event_counters
  import trib_cnt_pkg::*;
#(
  parameter int WIDE_W = 12,
  parameter int PTR_W  = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bip_err_i,
  input  logic              rei_evt_i,
  input  logic              ptr_dec_i,
  input  logic              latch_ctl_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int HI_W = WIDE_W - BYTE_W;
  localparam int SH_W = PTR_W + HI_W;

  // snapshot edge detect
  logic latch_q;
  logic latch_edge;
  always_ff @(posedge clk) begin
    if (rst) latch_q <= 1'b0;
    else     latch_q <= latch_ctl_i;
  end
  assign latch_edge = latch_ctl_i & ~latch_q;

  // address decode
  logic sel_bip_lo, sel_bip_hi, sel_rei_lo, sel_shared;
  assign sel_bip_lo = (rd_addr_i == ADDR_W'(OFS_BIP_LO));
  assign sel_bip_hi = (rd_addr_i == ADDR_W'(OFS_BIP_HI));
  assign sel_rei_lo = (rd_addr_i == ADDR_W'(OFS_REI_LO));
  assign sel_shared = (rd_addr_i == ADDR_W'(OFS_SHARED));

  logic [N_WIDE-1:0] wide_evt, clr_lo, clr_hi;
  assign wide_evt = {rei_evt_i, bip_err_i};
  assign clr_lo   = {rd_en_i & sel_rei_lo, rd_en_i & sel_bip_lo};
  assign clr_hi   = {rd_en_i & sel_shared, rd_en_i & sel_bip_hi};

  logic [WIDE_W-1:0] wide_live [N_WIDE];
  logic [BYTE_W-1:0] hold_lo   [N_WIDE];
  logic [HI_W-1:0]   hold_hi   [N_WIDE];

  for (genvar g = 0; g < N_WIDE; g++) begin : g_wide
    trib_live_cnt #(.W(WIDE_W)) u_live (
      .clk       (clk),
      .rst       (rst),
      .evt_i     (wide_evt[g]),
      .restart_i (latch_edge),
      .cnt_o     (wide_live[g])
    );
    trib_hold_slice #(.W(BYTE_W)) u_lo (
      .clk        (clk),
      .rst        (rst),
      .load_i     (latch_edge),
      .load_val_i (wide_live[g][BYTE_W-1:0]),
      .clr_i      (clr_lo[g]),
      .q_o        (hold_lo[g])
    );
    trib_hold_slice #(.W(HI_W)) u_hi (
      .clk        (clk),
      .rst        (rst),
      .load_i     (latch_edge),
      .load_val_i (wide_live[g][WIDE_W-1:BYTE_W]),
      .clr_i      (clr_hi[g]),
      .q_o        (hold_hi[g])
    );
  end

  logic [PTR_W-1:0] ptr_live, ptr_q;
  trib_live_cnt #(.W(PTR_W)) u_ptr_live (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (ptr_dec_i),
    .restart_i (latch_edge),
    .cnt_o     (ptr_live)
  );
  trib_hold_slice #(.W(PTR_W)) u_ptr_hold (
    .clk        (clk),
    .rst        (rst),
    .load_i     (latch_edge),
    .load_val_i (ptr_live),
    .clr_i      (clr_hi[IDX_REI]),
    .q_o        (ptr_q)
  );

  // flat views for the checker
  logic [WIDE_W-1:0] bip_live, rei_live;
  logic [BYTE_W-1:0] bip_lo_q, rei_lo_q;
  logic [HI_W-1:0]   bip_hi_q, rei_hi_q;
  assign bip_live = wide_live[IDX_BIP];
  assign rei_live = wide_live[IDX_REI];
  assign bip_lo_q = hold_lo[IDX_BIP];
  assign rei_lo_q = hold_lo[IDX_REI];
  assign bip_hi_q = hold_hi[IDX_BIP];
  assign rei_hi_q = hold_hi[IDX_REI];

  // read mux and registered output
  logic [BYTE_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (sel_bip_lo)      rd_mux = bip_lo_q;
    else if (sel_bip_hi) rd_mux = BYTE_W'(bip_hi_q);
    else if (sel_rei_lo) rd_mux = rei_lo_q;
    else if (sel_shared) rd_mux = BYTE_W'({ptr_q, rei_hi_q});
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_mux;
  end

  logic unused_sh;
  assign unused_sh = (SH_W > BYTE_W);
endmodule

// File: rtl/trib_cnt_chk.sv
module trib_cnt_chk
  import trib_cnt_pkg::*;
#(
  parameter int WIDE_W = 12,
  parameter int PTR_W  = 4,
  parameter int ADDR_W = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     bip_err_i,
  input logic                     latch_edge,
  input logic                     rd_en_i,
  input logic [ADDR_W-1:0]        rd_addr_i,
  input logic [7:0]               rd_data_o,
  input logic [WIDE_W-1:0]        bip_live,
  input logic [PTR_W-1:0]         ptr_live,
  input logic [BYTE_W-1:0]        bip_lo_q,
  input logic [BYTE_W-1:0]        rei_lo_q,
  input logic [WIDE_W-BYTE_W-1:0] rei_hi_q,
  input logic [PTR_W-1:0]         ptr_q
);
  localparam logic [WIDE_W-1:0] WMAX = '1;
  localparam logic [PTR_W-1:0]  PMAX = '1;

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (rd_data_o == '0 && bip_live == '0 && ptr_q == '0 && bip_lo_q == '0));

  a_r4_bip_saturates: assert property (@(posedge clk) disable iff (rst)
    (bip_live == WMAX && !latch_edge) |=> bip_live == WMAX);

  a_r4_ptr_saturates: assert property (@(posedge clk) disable iff (rst)
    (ptr_live == PMAX && !latch_edge) |=> ptr_live == PMAX);

  a_r5_hold_steady: assert property (@(posedge clk) disable iff (rst)
    (!latch_edge && !rd_en_i) |=> ($stable(bip_lo_q) && $stable(rei_lo_q) &&
                                   $stable(rei_hi_q) && $stable(ptr_q)));

  a_r5_snapshot_loads: assert property (@(posedge clk) disable iff (rst)
    latch_edge |=> bip_lo_q == $past(bip_live[BYTE_W-1:0]));

  a_r6_restart_keeps_event: assert property (@(posedge clk) disable iff (rst)
    latch_edge |=> bip_live == {{(WIDE_W-1){1'b0}}, $past(bip_err_i)});

  a_r7_shared_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && rd_addr_i == ADDR_W'(OFS_SHARED) && !latch_edge)
      |=> (rei_hi_q == '0 && ptr_q == '0 && $stable(rei_lo_q)));

  a_r7_shared_read_data: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && rd_addr_i == ADDR_W'(OFS_SHARED))
      |=> rd_data_o[PTR_W+WIDE_W-BYTE_W-1:0] == $past({ptr_q, rei_hi_q}));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && rd_addr_i > ADDR_W'(OFS_SHARED)) |=> rd_data_o == '0);

  a_r10_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

bind trib_event_counters trib_cnt_chk #(
  .WIDE_W (WIDE_W),
  .PTR_W  (PTR_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bip_err_i  (bip_err_i),
  .latch_edge (latch_edge),
  .rd_en_i    (rd_en_i),
  .rd_addr_i  (rd_addr_i),
  .rd_data_o  (rd_data_o),
  .bip_live   (bip_live),
  .ptr_live   (ptr_live),
  .bip_lo_q   (bip_lo_q),
  .rei_lo_q   (rei_lo_q),
  .rei_hi_q   (rei_hi_q),
  .ptr_q      (ptr_q)
);

// File: tb/trib_event_counters_tb.sv
`timescale 1ns/1ps
module trib_event_counters_tb;
  localparam int ADDR_W = 4;

  logic clk = 1'b0;
  logic rst, bip, rei, ptr, latch, rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0] rd_data;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trib_event_counters #(.ADDR_W(ADDR_W)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .bip_err_i   (bip),
    .rei_evt_i   (rei),
    .ptr_dec_i   (ptr),
    .latch_ctl_i (latch),
    .rd_en_i     (rd_en),
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data)
  );

  typedef struct packed {
    int unsigned nb; int unsigned nr; int unsigned np;
    int unsigned eb; int unsigned er; int unsigned ep;
  } vec_t;

  // stimulus event counts, then expected (saturated) tallies
  localparam vec_t VECS [4] = '{
    '{5,    3,    2,  5,    3,    2},
    '{421,  300,  15, 421,  300,  15},
    '{4100, 4095, 20, 4095, 4095, 15},
    '{0,    1,    0,  0,    1,    0}
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=0x%02h exp=0x%02h", req, got, exp);
    end
  endtask

  task automatic pulse_events(input int unsigned nb, input int unsigned nr, input int unsigned np);
    int unsigned mx;
    mx = nb;
    if (nr > mx) mx = nr;
    if (np > mx) mx = np;
    for (int unsigned i = 0; i < mx; i++) begin
      bip = (i < nb); rei = (i < nr); ptr = (i < np);
      step();
    end
    bip = 0; rei = 0; ptr = 0;
  endtask

  task automatic latch_pulse();
    latch = 1; step();
    latch = 0; step();
  endtask

  task automatic read_byte(input int addr, output logic [7:0] d);
    rd_en = 1; rd_addr = ADDR_W'(addr);
    step();
    rd_en = 0;
    d = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements) got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst = 1; bip = 0; rei = 0; ptr = 0; latch = 0; rd_en = 0; rd_addr = '0;
    repeat (5) step();
    rst = 0;
    step();
    check("R1 rd_data after reset", rd_data, 8'h00);
    latch_pulse();
    for (int a = 0; a < 4; a++) begin
      read_byte(a, d);
      check("R1 empty tally after reset", d, 8'h00);
    end

    // table walk: R2 R3 R4 layout and saturation
    for (int v = 0; v < 4; v++) begin
      pulse_events(VECS[v].nb, VECS[v].nr, VECS[v].np);
      latch_pulse();
      read_byte(0, d); check("R2 bip low byte",  d, 8'(VECS[v].eb));
      read_byte(1, d); check("R2 bip high byte", d, {4'h0, 4'(VECS[v].eb >> 8)});
      read_byte(2, d); check("R3 rei low byte",  d, 8'(VECS[v].er));
      read_byte(3, d); check("R3 R4 shared byte", d, {4'(VECS[v].ep), 4'(VECS[v].er >> 8)});
    end

    // R5: level held high does not relatch
    pulse_events(3, 0, 0);
    latch = 1; step();
    pulse_events(5, 0, 0);
    read_byte(0, d); check("R5 held level no relatch", d, 8'd3);
    latch = 0; step();
    latch = 1; step();
    latch = 0; step();
    read_byte(0, d); check("R5 second edge captures", d, 8'd5);

    // R6: event in the snapshot cycle survives
    pulse_events(2, 0, 0);
    latch = 1; bip = 1; step();
    latch = 0; bip = 0; step();
    read_byte(0, d); check("R6 snapshot value", d, 8'd2);
    latch_pulse();
    read_byte(0, d); check("R6 same-cycle event kept", d, 8'd1);

    // R7: per-byte clearing (bip 0x1A5, rei 0x12C, ptr 3)
    pulse_events(421, 300, 3);
    latch_pulse();
    read_byte(0, d); check("R7 bip low value",    d, 8'hA5);
    read_byte(0, d); check("R7 bip low cleared",  d, 8'h00);
    read_byte(1, d); check("R7 bip high untouched", d, 8'h01);
    read_byte(1, d); check("R7 bip high cleared", d, 8'h00);
    read_byte(3, d); check("R7 shared value",     d, 8'h31);
    read_byte(2, d); check("R7 rei low untouched", d, 8'h2C);
    read_byte(3, d); check("R7 shared cleared",   d, 8'h00);
    read_byte(2, d); check("R7 rei low cleared",  d, 8'h00);

    // R8: snapshot and read in one cycle
    pulse_events(9, 0, 0);
    latch_pulse();
    pulse_events(4, 0, 0);
    latch = 1; rd_en = 1; rd_addr = ADDR_W'(0);
    step();
    latch = 0; rd_en = 0;
    check("R8 read returns old snapshot", rd_data, 8'd9);
    step();
    read_byte(0, d); check("R8 new snapshot kept", d, 8'd4);
    read_byte(1, d); check("R8 high byte zero", d, 8'h00);

    // R9: unmapped offsets
    pulse_events(6, 0, 0);
    latch_pulse();
    read_byte(5, d);  check("R9 offset 5 reads zero", d, 8'h00);
    read_byte(15, d); check("R9 offset 15 reads zero", d, 8'h00);
    read_byte(0, d);  check("R9 no clear on unmapped", d, 8'd6);

    // R10: output holds while idle
    pulse_events(7, 0, 0);
    latch_pulse();
    read_byte(0, d); check("R10 read value", d, 8'd7);
    pulse_events(3, 2, 1);
    latch_pulse();
    rd_addr = ADDR_W'(2);
    step();
    check("R10 idle output held", rd_data, 8'd7);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule